// File: doc/BRIEF.md
# Two-Way Interleave Mismatch Corrector and Merger

This block sits behind a pair of sub-converters that sample the same input on alternate clock phases. One path captures the even-numbered samples and the other captures the odd-numbered samples. Their gain, phase and delay do not quite match, and that leaves an image in the merged full-rate signal. The correction is relative. The even path is the reference and only gets a programmable gain. The odd path gets its own gain, plus a programmable eight-tap crossover FIR that is fed from the history of the even path. The crossover FIR is what allows a phase and delay correction, which a gain alone cannot provide.

On each accepted input pair the block computes one corrected even sample and one corrected odd sample. It sends them out on one full-rate stream, even sample first, one sample per cycle. Software, or a calibration engine outside the block, writes coefficients into a pending set through an address/data port. A commit strobe copies the whole pending set into the active set in a single cycle, so the datapath never runs with a half-updated set. The power-on coefficient set is the identity set, which passes the input pairs through unchanged.

Top module: `ilv_skew_corrector`

## Requirements
- R1: The corrected even sample is `round(in_even * gain_even)`. `gain_even` is a signed 16-bit value with 14 fraction bits, so 0x4000 means 1.0. Rounding adds one half LSB and then floors (ties go toward plus infinity).
- R2: The corrected odd sample is `round(in_odd * gain_odd + sum over k=0..7 of xtap[k] * e[n-k])`. `gain_odd` has the same format as `gain_even`. Each `xtap[k]` is signed 16-bit with 15 fraction bits. `e[n]` is the even input of the current pair and `e[n-k]` is the even input accepted k pairs earlier, with zero before any pair was accepted. Rounding is the same as in R1.
- R3: A write with `cfg_we` high updates only the pending set. The active set, and therefore the output, changes only on a cycle with `cfg_commit` high, and then the whole pending set is copied at once.
- R4: Coefficient address map: 0 is `gain_even`, 1 is `gain_odd`, and 2+k is `xtap[k]` for k = 0..7. Writes to addresses 10 to 15 change nothing.
- R5: After reset both gains are 0x4000 and all taps are zero, in the active set and in the pending set. With this identity set the output stream equals the interleaved inputs bit for bit.
- R6: A pair is accepted at the clock edge where `in_valid` is sampled high. After that edge `out_data` carries the corrected even sample with `out_valid` high. After the next edge it carries the corrected odd sample with `out_valid` high. On every other cycle `out_valid` is low.
- R7: Any result outside the 16-bit signed range saturates to 32767 or to -32768.
- R8: An `in_valid` in the cycle right after an accepted pair is ignored. That pair is not emitted and does not enter the even-sample history.
- R9: When `cfg_commit` falls on the same edge as an accepted pair, that pair is computed with the old active set, and later pairs use the new set. A pending write on the commit edge itself is not part of the set committed on that edge.
- R10: Reset is synchronous and active high. It clears the even-sample history, drops `out_valid`, drives `out_data` to zero and restores the identity set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input pair is presented |
| in_even | input | 16 | Even-path (reference) sample, signed |
| in_odd | input | 16 | Odd-path sample, signed |
| cfg_we | input | 1 | Write `cfg_wdata` into the pending coefficient at `cfg_addr` |
| cfg_addr | input | 4 | Coefficient address |
| cfg_wdata | input | 16 | Coefficient value |
| cfg_commit | input | 1 | Copy the pending set to the active set |
| out_valid | output | 1 | `out_data` holds a corrected sample |
| out_data | output | 16 | Full-rate corrected sample stream, signed |

## Verification
Two kinds of event can share one edge. The first is a commit strobe that lands on the same edge as an accepted input pair. The bench provokes this by raising `cfg_commit` together with `in_valid`. It then expects that pair's odd sample to come from the old crossover taps and the following pair's to come from the new ones. The second is a pending write that lands on the commit edge itself. The bench expects the committed set to exclude that write, and a later commit to include it. A reference model in the bench follows the same rules, and both outcomes are compared against it at the output port.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int DATA_W         = 16;
    localparam int COEF_W         = 16;
    localparam int NUM_XTAPS      = 8;
    localparam int GAIN_FRAC      = 14;
    localparam int XTAP_FRAC      = 15;
    localparam int NUM_COEFS      = NUM_XTAPS + 2;
    localparam int CFG_ADDR_W     = $clog2(NUM_COEFS);
    localparam int ACC_W          = DATA_W + COEF_W + 2 + $clog2(NUM_COEFS);
    localparam int ADDR_GAIN_EVEN = 0;
    localparam int ADDR_GAIN_ODD  = 1;
    localparam int ADDR_XTAP_BASE = 2;
    localparam int SAMPLE_MAX     = (1 << (DATA_W - 1)) - 1;
    localparam int SAMPLE_MIN     = -(1 << (DATA_W - 1));

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    localparam coef_t GAIN_UNITY = coef_t'(1 << GAIN_FRAC);

    typedef struct packed {
        coef_t                            g_even;
        coef_t                            g_odd;
        logic [NUM_XTAPS-1:0][COEF_W-1:0] xtap;
    } coef_set_t;

    typedef struct packed {
        sample_t z_even;
        sample_t z_odd;
    } pair_t;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_ODD  = 1'b1
    } ser_state_t;

    function automatic coef_set_t identity_set();
        coef_set_t s;
        s.g_even = GAIN_UNITY;
        s.g_odd  = GAIN_UNITY;
        s.xtap   = '0;
        return s;
    endfunction

    // gain product brought onto the tap product scale
    function automatic acc_t gain_term(sample_t x, coef_t g);
        acc_t p;
        p = acc_t'(x) * acc_t'(g);
        return p <<< (XTAP_FRAC - GAIN_FRAC);
    endfunction

    function automatic acc_t tap_term(sample_t x, coef_t c);
        return acc_t'(x) * acc_t'(c);
    endfunction

    function automatic sample_t round_sat(acc_t a);
        acc_t r;
        r = (a + (acc_t'(1) <<< (XTAP_FRAC - 1))) >>> XTAP_FRAC;
        if (r > acc_t'(SAMPLE_MAX))
            return sample_t'(SAMPLE_MAX);
        else if (r < acc_t'(SAMPLE_MIN))
            return sample_t'(SAMPLE_MIN);
        else
            return sample_t'(r);
    endfunction

endpackage

// File: rtl/ilv_coef_bank.sv
module ilv_coef_bank
    import ilv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CFG_ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0]     wr_data,
    input  logic                  commit,
    output coef_set_t             active
);

    coef_set_t pending;

    // the commit copies the pending set as it stood before this edge's write
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= identity_set();
        end else if (commit) begin
            active <= pending;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= identity_set();
        end else if (wr_en) begin
            if (wr_addr == CFG_ADDR_W'(ADDR_GAIN_EVEN))
                pending.g_even <= coef_t'(wr_data);
            if (wr_addr == CFG_ADDR_W'(ADDR_GAIN_ODD))
                pending.g_odd <= coef_t'(wr_data);
            for (int k = 0; k < NUM_XTAPS; k++) begin
                if (wr_addr == CFG_ADDR_W'(ADDR_XTAP_BASE + k))
                    pending.xtap[k] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/ilv_xover_fir.sv
module ilv_xover_fir
    import ilv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  sample_t   in_even,
    input  sample_t   in_odd,
    input  coef_set_t coefs,
    output pair_t     corr
);

    sample_t tap_in [NUM_XTAPS];
    acc_t    xprod  [NUM_XTAPS];
    acc_t    xsum;

    assign tap_in[0] = in_even;

    generate
        for (genvar k = 1; k < NUM_XTAPS; k++) begin : g_dly
            sample_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (take)
                    q <= tap_in[k-1];
            end
            assign tap_in[k] = q;
        end
        for (genvar k = 0; k < NUM_XTAPS; k++) begin : g_prod
            assign xprod[k] = tap_term(tap_in[k], coef_t'(coefs.xtap[k]));
        end
    endgenerate

    always_comb begin
        xsum = '0;
        for (int k = 0; k < NUM_XTAPS; k++)
            xsum = xsum + xprod[k];
    end

    assign corr.z_even = round_sat(gain_term(in_even, coefs.g_even));
    assign corr.z_odd  = round_sat(gain_term(in_odd, coefs.g_odd) + xsum);

endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer
    import ilv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  pair_t   corr,
    output logic    take,
    output logic    out_valid,
    output sample_t out_data
);

    ser_state_t st;
    sample_t    odd_hold;

    assign take = in_valid && (st == SER_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SER_IDLE;
            out_valid <= 1'b0;
            out_data  <= '0;
            odd_hold  <= '0;
        end else if (take) begin
            out_data  <= corr.z_even;
            odd_hold  <= corr.z_odd;
            out_valid <= 1'b1;
            st        <= SER_ODD;
        end else if (st == SER_ODD) begin
            out_data  <= odd_hold;
            out_valid <= 1'b1;
            st        <= SER_IDLE;
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ilv_skew_corrector.sv
module ilv_skew_corrector
    import ilv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_even,
    input  logic [DATA_W-1:0]     in_odd,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0]     cfg_wdata,
    input  logic                  cfg_commit,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data
);

    coef_set_t active_set;
    pair_t     corr;
    logic      pair_take;
    sample_t   out_s;

    ilv_coef_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .commit  (cfg_commit),
        .active  (active_set)
    );

    ilv_xover_fir u_fir (
        .clk     (clk),
        .rst     (rst),
        .take    (pair_take),
        .in_even (sample_t'(in_even)),
        .in_odd  (sample_t'(in_odd)),
        .coefs   (active_set),
        .corr    (corr)
    );

    ilv_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .corr      (corr),
        .take      (pair_take),
        .out_valid (out_valid),
        .out_data  (out_s)
    );

    assign out_data = out_s;

endmodule

// File: rtl/ilv_skew_corrector_chk.sv
module ilv_skew_corrector_chk
    import ilv_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_we,
    input logic [CFG_ADDR_W-1:0] cfg_addr,
    input logic [COEF_W-1:0]     cfg_wdata,
    input logic                  cfg_commit,
    input logic                  pair_take,
    input logic                  out_valid,
    input coef_set_t             active_set
);

    AST_EVEN_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (rst)
        pair_take |=> out_valid);                                            // R6

    AST_ODD_SECOND_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pair_take |-> ##2 out_valid);                                        // R6

    AST_NO_BACK_TO_BACK_TAKE: assert property (@(posedge clk) disable iff (rst)
        pair_take |=> !pair_take);                                           // R8

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cfg_commit |=> $stable(active_set));                                // R3

    AST_COMMIT_TAKES_ODD_GAIN: assert property (@(posedge clk) disable iff (rst)
        (cfg_commit && $past(cfg_we && cfg_addr == CFG_ADDR_W'(ADDR_GAIN_ODD)))
        |=> (active_set.g_odd == coef_t'($past(cfg_wdata, 2))));             // R9

endmodule

bind ilv_skew_corrector ilv_skew_corrector_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_commit (cfg_commit),
    .pair_take  (pair_take),
    .out_valid  (out_valid),
    .active_set (active_set)
);

// File: tb/sim_ilv_skew_corrector.sv
`timescale 1ns/1ps
module sim_ilv_skew_corrector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_even = '0;
    logic [15:0] in_odd = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_commit = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_err = 0;

    // bench-side model state: active (m_) and pending (p_) sets, even history
    int m_g0, m_g1, p_g0, p_g1;
    int m_c [8];
    int p_c [8];
    int h   [8];

    // identity stimulus table: even, odd, expected first, expected second
    localparam logic [15:0] ID_VEC [0:5][0:3] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000},
        '{16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF},
        '{16'h0001, 16'hFFFF, 16'h0001, 16'hFFFF},
        '{16'h1234, 16'hEDCB, 16'h1234, 16'hEDCB},
        '{16'h4000, 16'hC000, 16'h4000, 16'hC000}
    };

    ilv_skew_corrector u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rsat(input longint a);
        longint r;
        r = (a + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int s16(input int v);
        return int'($signed(16'(v)));
    endfunction

    task automatic model_reset();
        m_g0 = 16384; m_g1 = 16384; p_g0 = 16384; p_g1 = 16384;
        for (int k = 0; k < 8; k++) begin m_c[k] = 0; p_c[k] = 0; h[k] = 0; end
    endtask

    task automatic model_write(input int addr, input int val);
        if (addr == 0) p_g0 = s16(val);
        else if (addr == 1) p_g1 = s16(val);
        else if (addr >= 2 && addr <= 9) p_c[addr-2] = s16(val);
    endtask

    task automatic model_commit();
        m_g0 = p_g0; m_g1 = p_g1;
        for (int k = 0; k < 8; k++) m_c[k] = p_c[k];
    endtask

    task automatic model_pair(input int e, input int o, output int x0, output int x1);
        longint a;
        for (int k = 7; k > 0; k--) h[k] = h[k-1];
        h[0] = s16(e);
        x0 = rsat(2 * longint'(m_g0) * longint'(s16(e)));
        a = 2 * longint'(m_g1) * longint'(s16(o));
        for (int k = 0; k < 8; k++) a = a + longint'(m_c[k]) * longint'(h[k]);
        x1 = rsat(a);
    endtask

    task automatic cfg_write(input int addr, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(val);
        @(posedge clk);
        model_write(addr, val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_commit_pulse();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(posedge clk);
        model_commit();
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    // one pair; optional commit on the same edge; checks both output samples
    task automatic run_pair(input int e, input int o, input bit with_commit, input string req);
        int x0, x1;
        @(negedge clk);
        in_valid = 1'b1; in_even = 16'(e); in_odd = 16'(o); cfg_commit = with_commit;
        model_pair(e, o, x0, x1);
        @(posedge clk);
        if (with_commit) model_commit();
        @(negedge clk);
        in_valid = 1'b0; cfg_commit = 1'b0;
        check(req, "even valid", int'(out_valid), 1);
        check(req, "even sample", s16(int'(out_data)), x0);
        @(posedge clk);
        @(negedge clk);
        check(req, "odd valid", int'(out_valid), 1);
        check(req, "odd sample", s16(int'(out_data)), x1);
    endtask

    task automatic load_set(input int g0, input int g1, input int c0, input int c1,
                            input int c2, input int c7);
        cfg_write(0, g0); cfg_write(1, g1);
        cfg_write(2, c0); cfg_write(3, c1); cfg_write(4, c2);
        cfg_write(5, 0); cfg_write(6, 16'h0100); cfg_write(7, 16'hFF80);
        cfg_write(8, 16'h0040); cfg_write(9, c7);
        cfg_commit_pulse();
    endtask

    initial begin
        #1_000_000;
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state at the port
        check("R10", "reset out_valid", int'(out_valid), 0);
        check("R10", "reset out_data", int'(out_data), 0);

        // R5, R6: identity set passes the table through, even first
        for (int i = 0; i < 6; i++) begin
            int x0, x1;
            @(negedge clk);
            in_valid = 1'b1; in_even = ID_VEC[i][0]; in_odd = ID_VEC[i][1];
            model_pair(int'(ID_VEC[i][0]), int'(ID_VEC[i][1]), x0, x1);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check("R5", "identity even", int'(out_data), int'(ID_VEC[i][2]));
            check("R6", "even valid", int'(out_valid), 1);
            @(posedge clk);
            @(negedge clk);
            check("R5", "identity odd", int'(out_data), int'(ID_VEC[i][3]));
            @(posedge clk);
            @(negedge clk);
            check("R6", "idle valid low", int'(out_valid), 0);
        end

        // R3: pending writes without commit leave the output alone
        cfg_write(1, 16'h2000);
        cfg_write(4, 16'h4000);
        run_pair(16'h0300, 16'h0500, 1'b0, "R3");

        // R1, R2, R4: loaded set over a varied stream
        load_set(16'h3E00, 16'h4200, 16'h0800, 16'hFC00, 16'h0200, 16'h1000);
        for (int i = 0; i < 12; i++) begin
            run_pair(((i * 7919) % 60000) - 30000, ((i * 4513) % 50000) - 25000, 1'b0, "R2");
        end
        run_pair(16'h1000, 16'h0000, 1'b0, "R1");

        // R4: writes above the map change nothing
        cfg_write(12, 16'h7FFF);
        cfg_write(15, 16'h1234);
        cfg_commit_pulse();
        run_pair(16'h0777, 16'hF111, 1'b0, "R4");

        // R9: commit on the same edge as a pair
        cfg_write(2, 16'h7000);
        cfg_write(9, 16'h8000);
        run_pair(16'h2000, 16'h0100, 1'b1, "R9 old set");
        run_pair(16'h2000, 16'h0100, 1'b0, "R9 new set");

        // R9: write on the commit edge is excluded from that commit
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 16'h6000; cfg_commit = 1'b1;
        @(posedge clk);
        model_commit();
        model_write(1, 16'h6000);
        @(negedge clk);
        cfg_we = 1'b0; cfg_commit = 1'b0;
        run_pair(16'h0000, 16'h1000, 1'b0, "R9 write excluded");
        cfg_commit_pulse();
        run_pair(16'h0000, 16'h1000, 1'b0, "R9 write included");

        // R7: saturation both ways
        load_set(16'h8000, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        run_pair(16'h8000, 16'h7FFF, 1'b0, "R7");
        run_pair(16'h7FFF, 16'h8000, 1'b0, "R7");
        run_pair(16'h4000, 16'hC000, 1'b0, "R7");

        // R8: pair in the cycle after an accepted pair is ignored
        begin
            int x0, x1, y0, y1;
            @(negedge clk);
            in_valid = 1'b1; in_even = 16'h1111; in_odd = 16'h2222;
            model_pair(16'h1111, 16'h2222, x0, x1);
            @(posedge clk);
            @(negedge clk);
            in_even = 16'h7777; in_odd = 16'h6666;
            check("R8", "even of kept pair", s16(int'(out_data)), x0);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check("R8", "odd of kept pair", s16(int'(out_data)), x1);
            @(posedge clk);
            @(negedge clk);
            check("R8", "ignored pair not emitted", int'(out_valid), 0);
            y0 = 0; y1 = 0;
            run_pair(16'h0123, 16'h0456, 1'b0, "R8 history");
        end

        // R10: reset mid-stream clears history and restores identity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R10", "valid after reset", int'(out_valid), 0);
        check("R10", "data after reset", int'(out_data), 0);
        run_pair(16'h5555, 16'hAAAA, 1'b0, "R10 identity");
        load_set(16'h4000, 16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h4000);
        run_pair(16'h0000, 16'h0000, 1'b0, "R10 history cleared");

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule